// File: doc/BRIEF.md
# Serial Memory Bridge

This block gives a PC direct read and write access to a shared memory space over a serial line. The host processor keeps running while this happens. The PC sends short command frames into the receive pin. A fixed state machine decodes each frame and turns it into byte-wide memory requests. It returns the read data and a completion status on the transmit pin. No processor is involved at any point.

Memory requests go to an external arbiter through a request/grant handshake. The arbiter serves the host first and grants a bridge request only in a cycle the host leaves free, so the host's own access timing does not change. The address is 24 bits wide. It covers a one-megabyte region that holds graphics-ROM content, which can then be loaded from a PC rather than being fixed when the device is configured. It also covers the external memory behind the host's cartridge window.

Top module: `serial_mem_bridge`

## Requirements
- R1: Every transmitted bit lasts 16*OS_DIV clock cycles. OS_DIV is CLK_HZ/(16*BAUD) rounded to the nearest integer, and the default BAUD is 230400.
- R2: The receiver starts a byte on a falling edge of the line. It confirms the start bit half a bit later. It then samples eight data bits, least significant first, at their midpoints. A byte whose stop bit samples low is discarded and produces no effect.
- R3: A write frame is the byte 0x02, then a 24-bit big-endian address, then a 16-bit big-endian count, then the data bytes. The bridge stores the data bytes at ascending addresses. After the last byte is stored it sends the single byte 0x00.
- R4: A read frame is the byte 0x01 followed by the same address and count fields. The bridge sends exactly the count of data bytes, read from ascending addresses, and then the byte 0x00.
- R5: Any first byte other than 0x01 or 0x02 is answered with 0xFF. The byte after it is decoded as a new first byte.
- R6: Once raised, the memory request holds its address, write flag and write data unchanged until a grant is seen. It is dropped in the cycle after the grant, so each byte costs exactly one granted access.
- R7: A count of zero makes a read or write frame reply with 0x00 alone, with no memory access.
- R8: The parser drops a partly received frame when more than TIMEOUT_BITS bit periods pass without a byte while it waits for header or write data. It then returns to waiting for a first byte.
- R9: Addresses are 24 bits and increment with full carry. A transfer may cross any 64 KiB boundary, and addresses 0x006000..0x007FFF and 0x000000..0x0FFFFF are all reachable.
- R10: After reset the transmit line is high and no memory request is pending. The line stays high whenever no byte is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial data from the PC |
| txd | output | 1 | Serial data to the PC |
| mem_req | output | 1 | Bridge memory request, held until granted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_gnt | input | 1 | One-cycle grant from the arbiter |
| mem_rdata | input | 8 | Read byte, valid in the grant cycle |

## Verification
The bench stretches grants with a randomly busy host. A bridge that let go of its request early, or kept it raised after the grant, would corrupt data or take an extra access per byte. Transfers crossing a 64 KiB boundary catch an address counter that carries into too few bits. A byte with a low stop bit, an unknown opcode and a stalled half header are each followed by a clean read. A parser that took the bad byte, consumed bytes after the 0xFF reply, or never timed out would then misread that frame. Zero-length frames catch a count that underflows into 65536 transfers.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam logic [7:0] OP_READ  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] ST_OK    = 8'h00;
  localparam logic [7:0] ST_BAD   = 8'hFF;
  localparam int OS_RATE = 16;

  typedef enum logic [2:0] {
    P_OP, P_HDR, P_WDAT, P_WREQ, P_RREQ, P_RSEND, P_STAT
  } pstate_t;
endpackage

// File: rtl/smb_tick_gen.sv
module smb_tick_gen #(
  parameter int DIV = 54
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = $clog2(DIV + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == W'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_uart_rx.sv
module smb_uart_rx #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       os_tick,
  input  logic       rxd,
  output logic       valid,
  output logic [7:0] data
);
  localparam int TW = $clog2(OS);
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_t;

  rx_st_t        st;
  logic [2:0]    sync;
  logic [TW-1:0] tcnt;
  logic [2:0]    nbit;
  logic [7:0]    sh;
  logic          line, falling;

  assign line    = sync[1];
  assign falling = sync[2] & ~sync[1];

  always_ff @(posedge clk) begin
    if (rst) sync <= 3'b111;
    else     sync <= {sync[1:0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= R_IDLE;
      tcnt  <= '0;
      nbit  <= '0;
      sh    <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= 1'b0;
      case (st)
        R_IDLE: if (falling) begin
          st   <= R_START;
          tcnt <= '0;
        end
        R_START: if (os_tick) begin
          if (tcnt == TW'(OS / 2 - 1)) begin
            tcnt <= '0;
            nbit <= '0;
            st   <= line ? R_IDLE : R_DATA;
          end else tcnt <= tcnt + TW'(1);
        end
        R_DATA: if (os_tick) begin
          if (tcnt == TW'(OS - 1)) begin
            tcnt <= '0;
            sh   <= {line, sh[7:1]};
            nbit <= nbit + 3'd1;
            if (nbit == 3'd7) st <= R_STOP;
          end else tcnt <= tcnt + TW'(1);
        end
        R_STOP: if (os_tick) begin
          if (tcnt == TW'(OS - 1)) begin
            tcnt <= '0;
            st   <= R_IDLE;
            if (line) begin
              valid <= 1'b1;
              data  <= sh;
            end
          end else tcnt <= tcnt + TW'(1);
        end
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_uart_tx.sv
module smb_uart_tx #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       os_tick,
  input  logic       start,
  input  logic [7:0] din,
  output logic       txd,
  output logic       busy
);
  localparam int TW = $clog2(OS);
  logic [8:0]    sh;
  logic [3:0]    nb;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      sh   <= '1;
      nb   <= '0;
      tcnt <= '0;
    end else if (!busy) begin
      if (start) begin
        txd  <= 1'b0;
        sh   <= {1'b1, din};
        busy <= 1'b1;
        nb   <= '0;
        tcnt <= '0;
      end
    end else if (os_tick) begin
      if (tcnt == TW'(OS - 1)) begin
        tcnt <= '0;
        if (nb == 4'd9) busy <= 1'b0;
        else begin
          txd <= sh[0];
          sh  <= {1'b1, sh[8:1]};
          nb  <= nb + 4'd1;
        end
      end else tcnt <= tcnt + TW'(1);
    end
  end
endmodule

// File: rtl/smb_parser.sv
module smb_parser
  import smb_pkg::*;
#(
  parameter int ADDR_BYTES   = 3,
  parameter int CNT_BYTES    = 2,
  parameter int OS           = 16,
  parameter int TIMEOUT_BITS = 65536,
  localparam int ADDR_W      = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              tx_busy,
  output logic              tx_start,
  output logic [7:0]        tx_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata
);
  localparam int CNT_W     = 8 * CNT_BYTES;
  localparam int HDR_BYTES = ADDR_BYTES + CNT_BYTES;
  localparam int HW        = ADDR_W + CNT_W;
  localparam int HIW       = $clog2(HDR_BYTES);
  localparam int TO_LIMIT  = TIMEOUT_BITS * OS;
  localparam int TOW       = $clog2(TO_LIMIT + 1);

  pstate_t           st;
  logic              op_wr;
  logic [HIW-1:0]    hdr_idx;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        rbyte, status;
  logic [TOW-1:0]    to_cnt;
  logic              waiting, to_hit;
  logic [HW-1:0]     hdr_next;
  logic [ADDR_W-1:0] hdr_addr;
  logic [CNT_W-1:0]  hdr_cnt;

  // header bytes shift in, most significant first, through address then count
  assign hdr_next = {addr_q[ADDR_W-9:0], cnt_q, rx_data};
  assign hdr_addr = hdr_next[HW-1:CNT_W];
  assign hdr_cnt  = hdr_next[CNT_W-1:0];

  // inter-byte silence watchdog, counted in oversample ticks
  assign waiting = (st == P_HDR) || (st == P_WDAT);
  assign to_hit  = waiting && !rx_valid && os_tick && (to_cnt == TOW'(TO_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !waiting || rx_valid) to_cnt <= '0;
    else if (os_tick)                to_cnt <= to_cnt + TOW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= P_OP;
      op_wr     <= 1'b0;
      hdr_idx   <= '0;
      addr_q    <= '0;
      cnt_q     <= '0;
      rbyte     <= '0;
      status    <= ST_OK;
      tx_start  <= 1'b0;
      tx_data   <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      tx_start <= 1'b0;
      case (st)
        P_OP: if (rx_valid) begin
          hdr_idx <= '0;
          if (rx_data == OP_READ) begin
            op_wr <= 1'b0;
            st    <= P_HDR;
          end else if (rx_data == OP_WRITE) begin
            op_wr <= 1'b1;
            st    <= P_HDR;
          end else begin
            status <= ST_BAD;
            st     <= P_STAT;
          end
        end
        P_HDR: if (rx_valid) begin
          addr_q  <= hdr_addr;
          cnt_q   <= hdr_cnt;
          hdr_idx <= hdr_idx + HIW'(1);
          if (hdr_idx == HIW'(HDR_BYTES - 1)) begin
            if (hdr_cnt == '0) begin
              status <= ST_OK;
              st     <= P_STAT;
            end else if (op_wr) begin
              st <= P_WDAT;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= hdr_addr;
              st       <= P_RREQ;
            end
          end
        end else if (to_hit) st <= P_OP;
        P_WDAT: if (rx_valid) begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= addr_q;
          mem_wdata <= rx_data;
          st        <= P_WREQ;
        end else if (to_hit) st <= P_OP;
        P_WREQ: if (mem_gnt) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          addr_q  <= addr_q + ADDR_W'(1);
          cnt_q   <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            status <= ST_OK;
            st     <= P_STAT;
          end else st <= P_WDAT;
        end
        P_RREQ: if (mem_gnt) begin
          mem_req <= 1'b0;
          rbyte   <= mem_rdata;
          st      <= P_RSEND;
        end
        P_RSEND: if (!tx_busy && !tx_start) begin
          tx_start <= 1'b1;
          tx_data  <= rbyte;
          addr_q   <= addr_q + ADDR_W'(1);
          cnt_q    <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            status <= ST_OK;
            st     <= P_STAT;
          end else begin
            // fetch the next byte while this one is shifted out
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= addr_q + ADDR_W'(1);
            st       <= P_RREQ;
          end
        end
        P_STAT: if (!tx_busy && !tx_start) begin
          tx_start <= 1'b1;
          tx_data  <= status;
          st       <= P_OP;
        end
        default: st <= P_OP;
      endcase
    end
  end
endmodule

// File: rtl/serial_mem_bridge.sv
module serial_mem_bridge
  import smb_pkg::*;
#(
  parameter int CLK_HZ       = 200_000_000,
  parameter int BAUD         = 230_400,
  parameter int ADDR_BYTES   = 3,
  parameter int CNT_BYTES    = 2,
  parameter int TIMEOUT_BITS = 65536,
  localparam int ADDR_W      = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  output logic              txd,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata
);
  localparam int OS_DIV_RAW = (CLK_HZ + (BAUD * OS_RATE) / 2) / (BAUD * OS_RATE);
  localparam int OS_DIV     = (OS_DIV_RAW < 1) ? 1 : OS_DIV_RAW;

  logic       os_tick;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       tx_start, tx_busy;
  logic [7:0] tx_data;

  smb_tick_gen #(.DIV(OS_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(os_tick)
  );

  smb_uart_rx #(.OS(OS_RATE)) u_rx (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
    .valid(rx_valid), .data(rx_data)
  );

  smb_uart_tx #(.OS(OS_RATE)) u_tx (
    .clk(clk), .rst(rst), .os_tick(os_tick), .start(tx_start),
    .din(tx_data), .txd(txd), .busy(tx_busy)
  );

  smb_parser #(
    .ADDR_BYTES(ADDR_BYTES), .CNT_BYTES(CNT_BYTES),
    .OS(OS_RATE), .TIMEOUT_BITS(TIMEOUT_BITS)
  ) u_parse (
    .clk(clk), .rst(rst), .os_tick(os_tick),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_busy(tx_busy), .tx_start(tx_start), .tx_data(tx_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/smb_bridge_chk.sv
module smb_bridge_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_gnt,
  input logic              tx_start,
  input logic              tx_busy,
  input logic              rx_valid,
  input logic              txd
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R6
  req_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt) |=> !mem_req);

  // R4
  tx_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !tx_busy);

  // R2
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R10
  line_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && !$past(tx_start)) |-> txd);
endmodule

bind serial_mem_bridge smb_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
  .tx_start(tx_start), .tx_busy(tx_busy), .rx_valid(rx_valid), .txd(txd)
);

// File: tb/tb_serial_mem_bridge.sv
module tb_serial_mem_bridge;
  localparam int CLK_HZ  = 11_059_200;   // gives OS_DIV = 3 at 230400
  localparam int BIT     = 48;           // 16 * 3 clocks per bit
  localparam int TO_BITS = 32;

  typedef struct packed {
    logic [23:0] a;
    logic [15:0] n;
    logic [7:0]  s;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'h000010, 16'd3, 8'h11},
    '{24'h006000, 16'd4, 8'h42},
    '{24'h007FFE, 16'd2, 8'hA5},
    '{24'h0F0000, 16'd5, 8'h3C},
    '{24'h00FFFE, 16'd3, 8'h77},
    '{24'h0FFFFE, 16'd4, 8'hC9}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic        txd, mem_req, mem_we, mem_gnt;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        host_busy;

  int pass_cnt = 0, total_cnt = 0, busy_pct = 50, run = 0;
  logic [7:0]  mem [0:4095];
  logic [7:0]  rxq [$];
  logic [23:0] gaddrq [$];
  int          lowq [$];

  always #2.5 clk = ~clk;

  serial_mem_bridge #(.CLK_HZ(CLK_HZ), .TIMEOUT_BITS(TO_BITS)) dut (
    .clk(clk), .rst(rst), .rxd(rxd), .txd(txd), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  // arbiter and memory model: the host wins, the bridge gets free slots
  initial begin
    mem_gnt = 1'b0; mem_rdata = 8'h00; host_busy = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  end
  always @(negedge clk) begin
    mem_gnt   = 1'b0;
    host_busy = ($urandom_range(99) < busy_pct);
    if (!rst && mem_req && !host_busy) begin
      mem_gnt = 1'b1;
      gaddrq.push_back(mem_addr);
      if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
      mem_rdata = mem[mem_addr[11:0]];
    end
  end

  // serial decoder on the transmit pin
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge txd);
      repeat (BIT / 2) @(negedge clk);
      if (txd == 1'b0) begin
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          b[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        if (txd) rxq.push_back(b);
      end
    end
  end

  // widths of low runs on the transmit pin, in clocks
  always @(negedge clk) begin
    if (txd === 1'b0) run = run + 1;
    else if (run != 0) begin
      lowq.push_back(run);
      run = 0;
    end
  end

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    total_cnt++;
    if (ok) pass_cnt++;
    else $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_ok = 1'b1);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    if (!stop_ok) repeat (BIT) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a, input logic [15:0] n);
    send_byte(op);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(n[15:8]);  send_byte(n[7:0]);
  endtask

  task automatic expect_byte(input string rq, input logic [7:0] exp);
    int w = 0;
    while (rxq.size() == 0 && w < 30 * BIT) begin
      @(negedge clk);
      w++;
    end
    if (rxq.size() == 0) check(1'b0, rq, -1, exp);
    else begin
      logic [7:0] b;
      b = rxq.pop_front();
      check(b == exp, rq, b, exp);
    end
  endtask

  task automatic expect_silence(input string rq, input int bits);
    repeat (bits * BIT) @(negedge clk);
    check(rxq.size() == 0, rq, rxq.size(), 0);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] s, input int i);
    return s + 8'(i * 37);
  endfunction

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R10: idle state after reset
    check(txd == 1'b1, "R10 txd idle", txd, 1);
    check(mem_req == 1'b0, "R10 no request", mem_req, 0);

    // table walk: write a pattern, then read it back
    foreach (VECS[k]) begin
      gaddrq.delete();
      send_hdr(8'h02, VECS[k].a, VECS[k].n);
      for (int i = 0; i < int'(VECS[k].n); i++) send_byte(pat(VECS[k].s, i));
      expect_byte("R3 write status", 8'h00);
      check(gaddrq.size() == int'(VECS[k].n), "R6 one access per byte", gaddrq.size(), VECS[k].n);
      for (int i = 0; i < gaddrq.size(); i++)
        check(gaddrq[i] == VECS[k].a + 24'(i), "R9 write address", gaddrq[i], VECS[k].a + 24'(i));
      send_hdr(8'h01, VECS[k].a, VECS[k].n);
      for (int i = 0; i < int'(VECS[k].n); i++) expect_byte("R4 read data", pat(VECS[k].s, i));
      expect_byte("R4 read status", 8'h00);
    end

    // R1: data bit widths on the wire
    send_hdr(8'h02, 24'h000200, 16'd1);
    send_byte(8'h55);
    expect_byte("R3 write status", 8'h00);
    repeat (2 * BIT) @(negedge clk);
    lowq.delete();
    send_hdr(8'h01, 24'h000200, 16'd1);
    expect_byte("R4 read data", 8'h55);
    expect_byte("R4 read status", 8'h00);
    for (int i = 1; i <= 4; i++)
      check(lowq.size() > i && lowq[i] == BIT, "R1 bit width", (lowq.size() > i) ? lowq[i] : -1, BIT);

    // R5: unknown opcode, then the next byte is an opcode
    send_byte(8'h33);
    expect_byte("R5 reject status", 8'hFF);
    send_hdr(8'h01, 24'h000200, 16'd1);
    expect_byte("R5 next frame data", 8'h55);
    expect_byte("R5 next frame status", 8'h00);

    // R2: byte with a low stop bit is dropped
    send_byte(8'h33, 1'b0);
    expect_silence("R2 bad stop ignored", 20);
    send_hdr(8'h01, 24'h000200, 16'd1);
    expect_byte("R2 following frame data", 8'h55);
    expect_byte("R2 following frame status", 8'h00);

    // R7: zero counts
    gaddrq.delete();
    send_hdr(8'h01, 24'h000200, 16'd0);
    expect_byte("R7 zero read status", 8'h00);
    expect_silence("R7 zero read no data", 12);
    send_hdr(8'h02, 24'h000200, 16'd0);
    expect_byte("R7 zero write status", 8'h00);
    check(gaddrq.size() == 0, "R7 no access", gaddrq.size(), 0);

    // R8: stalled header is dropped
    send_byte(8'h02); send_byte(8'h00); send_byte(8'h02);
    repeat ((TO_BITS + 8) * BIT) @(negedge clk);
    send_hdr(8'h01, 24'h000200, 16'd1);
    expect_byte("R8 data after timeout", 8'h55);
    expect_byte("R8 status after timeout", 8'h00);

    // R6: heavily loaded host still yields correct transfers
    busy_pct = 90;
    send_hdr(8'h02, 24'h000300, 16'd3);
    for (int i = 0; i < 3; i++) send_byte(pat(8'h5A, i));
    expect_byte("R6 busy write status", 8'h00);
    send_hdr(8'h01, 24'h000300, 16'd3);
    for (int i = 0; i < 3; i++) expect_byte("R6 busy read data", pat(8'h5A, i));
    expect_byte("R6 busy read status", 8'h00);
    check(txd == 1'b1 || rxq.size() == 0, "R10 line idle after traffic", txd, 1);

    $display("%0d/%0d checks passed", pass_cnt, total_cnt);
    $finish;
  end

  initial begin
    repeat (195_000) @(posedge clk);
    total_cnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", pass_cnt, total_cnt);
    $finish;
  end
endmodule